// File: doc/BRIEF.md
# Read-First Simple Dual-Port RAM

This block is a single-clock storage array with one port that only writes and one port that only reads, each driven by its own address. It is sized and shaped to hold the entries of a synchronous FIFO, where the write side and the read side advance independently but share one clock.

The write port stores `wr_data` at `wr_addr` on a rising edge where `wr_en` is high. The read port samples `rd_addr` on a rising edge where `rd_en` is high and presents the word on `rd_data` from that edge on. The output register keeps its value while `rd_en` is low.

When both ports name the same location in the same cycle, the read returns the word held before that write. The new word is visible only to later reads. This rule is fixed in the RTL, so a behavioural model and the built memory cannot give different answers on a collision. A design that returns the incoming data instead is counted as faulty.

Top module: `rfram_sdp`

## Requirements
- R1: While `rst_n` is low, `rd_data` is driven to zero, and it stays zero until the first enabled read after reset. Reset does not clear the stored words; their contents are undefined until written.
- R2: On a rising edge with `wr_en` high, the value of `wr_data` becomes the content of location `wr_addr`. Every later read of that location returns it until it is written again.
- R3: On a rising edge with `rd_en` high, the content of location `rd_addr` appears on `rd_data` right after that edge, which is one clock of latency.
- R4: On a rising edge with `rd_en` low, `rd_data` keeps its previous value, whatever the address and write inputs do.
- R5: When `rd_en` and `wr_en` are both high and `rd_addr` equals `wr_addr`, `rd_data` receives the content from before the write (read-first). A read of that location in the next cycle returns the new word.
- R6: On a rising edge with `wr_en` low, no location changes, whatever `wr_addr` and `wr_data` hold.
- R7: A write to one address does not disturb a read of a different address in the same cycle.
- R8: Address 0 and address `DEPTH-1` are stored and read like any other location. The address width is the ceiling of log2(`DEPTH`), with a minimum of one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read location |
| rd_data | output | WIDTH | Registered read word |

## Verification
The assertions take for granted that both addresses stay below `DEPTH`. They also take for granted that the inputs carry known values once reset is released, and that a location is read only after it has been written, so the old word compared on a collision is defined. The stimulus fills every location before the first read. It draws all addresses from the range 0 to `DEPTH-1`, and it drives every input to a known level at time zero. Collision pairs are issued back to back on the same address, including both ends of the array, so the read-first word and the newly written word can be seen on consecutive cycles.

// File: rtl/rfram_pkg.sv
package rfram_pkg;
    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_DEPTH = 64;

    // Address bits needed for a given depth, never fewer than one.
    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/rfram_array.sv
module rfram_array #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_word
);
    logic [WIDTH-1:0] store [DEPTH];

    // Storage is not reset; only the write strobe changes it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Asynchronous look-up of the currently held word; the read register
    // samples it on the same edge a write lands, so it sees the old word.
    assign rd_word = store[rd_addr];
endmodule

// File: rtl/rfram_rdport.sv
module rfram_rdport #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (en) begin
            word_q <= word_in;
        end
    end
endmodule

// File: rtl/rfram_sdp.sv
module rfram_sdp
    import rfram_pkg::*;
#(
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned ADDR_W = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] arr_word;

    rfram_array #(
        .WIDTH  (WIDTH),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (arr_word)
    );

    rfram_rdport #(
        .WIDTH (WIDTH)
    ) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rd_en),
        .word_in (arr_word),
        .word_q  (rd_data)
    );
endmodule

// File: rtl/rfram_sdp_chk.sv
module rfram_sdp_chk #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WIDTH-1:0]  arr_word,
    input logic [WIDTH-1:0]  rd_data
);
    // R1: a cycle in reset leaves the read register at zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

    // R3: enabled read presents the array word one edge later
    a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(arr_word)));

    // R4: output holds while the read strobe is low
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R5: a same-address collision must not return the incoming word
    a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && (rd_addr == wr_addr) && (wr_data != arr_word))
        |=> (rd_data != $past(wr_data)));

    // R2: a write is visible at its address on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_addr != $past(wr_addr)) || (arr_word == $past(wr_data))));
endmodule

bind rfram_sdp rfram_sdp_chk #(
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .arr_word (arr_word),
    .rd_data  (rd_data)
);

// File: tb/rfram_sdp_test.sv
module rfram_sdp_test;
    localparam int W  = 16;
    localparam int D  = 64;
    localparam int AW = 6;

    typedef struct {
        bit          chk;
        logic [W-1:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;

    int n_vec = 0;
    int n_bad = 0;

    item_t        sbq[$];
    logic [W-1:0] shadow [D];
    bit           written [D];
    logic [W-1:0] model_q = '0;
    bit           model_ok = 1'b1;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    rfram_sdp #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [W-1:0] pat(input int a, input int p);
        return W'((a * 16'h0131) ^ (p * 16'h5a3c) ^ 16'h0f0f);
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one clock of stimulus; expected read result queued at the edge.
    task automatic cyc(input bit we, input int wa, input logic [W-1:0] wd,
                       input bit re, input int ra, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        rd_en = re; rd_addr = AW'(ra);
        @(posedge clk);
        if (re) begin
            model_ok = written[ra];
            model_q  = shadow[ra];          // old word: read-first
        end
        it.chk = model_ok; it.exp = model_q; it.tag = tag;
        sbq.push_back(it);
        if (we) begin
            shadow[wa]  = wd;
            written[wa] = 1'b1;
        end
    endtask

    // Monitor: compare away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                if (it.chk) check(rd_data, it.exp, it.tag);
            end
        end
    end

    initial begin
        for (int i = 0; i < D; i++) written[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_data, '0, "R1 reset");
        rst_n = 1'b1;
        // R1: no read yet, output still zero
        cyc(0, 0, '0, 0, 0, "R1 after release");

        // R2/R8: fill every location, including 0 and D-1
        for (int a = 0; a < D; a++) cyc(1, a, pat(a, 1), 0, 0, "R1 idle fill");
        for (int a = 0; a < D; a++) cyc(0, 0, '0, 1, a, "R2 R3 readback");
        cyc(0, 0, '0, 1, 0,     "R8 low end");
        cyc(0, 0, '0, 1, D - 1, "R8 high end");

        // R6: disabled writes leave contents alone
        cyc(0, 5, 16'hdead, 0, 0, "R6 masked write");
        cyc(0, 5, 16'hbeef, 1, 5, "R6 masked write readback");
        cyc(0, 0, '0, 1, 5, "R6 location intact");

        // R4: read strobe low, address and writes moving
        cyc(0, 0, '0, 1, 9, "R3 load");
        for (int k = 0; k < 6; k++) cyc(k[0], 20 + k, pat(k, 7), 0, 30 + k, "R4 hold");

        // R5: back-to-back same-address collision pairs
        for (int a = 0; a < D; a += 9) begin
            cyc(1, a, pat(a, 2), 1, a, "R5 collision old word");
            cyc(0, 0, '0, 1, a, "R5 new word next read");
        end
        cyc(1, D - 1, pat(D - 1, 3), 1, D - 1, "R5 R8 collision top");
        cyc(1, D - 1, pat(D - 1, 4), 1, D - 1, "R5 chained collision");
        cyc(0, 0, '0, 1, D - 1, "R5 final word");

        // R7: write elsewhere during read
        for (int k = 0; k < 8; k++) cyc(1, k + 40, pat(k, 5), 1, k + 48, "R7 independent");
        for (int k = 0; k < 8; k++) cyc(0, 0, '0, 1, k + 40, "R7 writes landed");

        // R1: reset again clears output
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(rd_data, '0, "R1 second reset");
        rst_n = 1'b1;
        cyc(0, 0, '0, 1, 3, "R2 contents survive reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cycles = 0;
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule